// File: doc/BRIEF.md
# MSI Coalescing Gate

This block services one trigger at a time for a numbered message-signalled interrupt source. It takes the source number and checks it against a table-enable flag and a table length. From the table base and a per-entry stride it forms the address of that source's 8-byte descriptor in memory. It then reads the descriptor over a plain request/response memory port and byte-swaps it into big-endian order. From the result it extracts a destination server, a priority, a generation value and two coalescing flags: P (an interrupt is in flight) and Q (another one arrived meanwhile).

The two flags and the priority decide the outcome. The block either claims the interrupt by setting P and emitting a one-cycle delivery pulse, or remembers it by setting Q, or drops it. Flag updates are single-byte writes into the descriptor. A force input makes the block act as if both flags were clear, which serves replay of interrupts that were earlier rejected.

The trigger input is valid/ready: a trigger transfers on a cycle where both are high, and ready is high only while the block is idle. The memory request is valid/ready: once raised, a request and its address, direction and data are held unchanged until the memory accepts. Responses carry no back-pressure. They are consumed on any cycle where the block waits for one, and are ignored at any other time. The delivery output and the error flag are one-cycle pulses with no back-pressure.

Top module: `msi_pq_gate`

## Requirements
- R1: A trigger is taken only while `trig_ready` is high, which happens exactly when `busy` is low. After a trigger that passes the lookup checks, `busy` rises on the next cycle together with a read request, and stays high until the operation ends.
- R2: If `cfg_tbl_en` is low when a trigger is taken, the trigger is discarded: no memory request, no delivery, and `busy` stays low.
- R3: A source number greater than or equal to `cfg_tbl_len` is discarded in the same way as in R2. The source `cfg_tbl_len`-1 is still serviced.
- R4: The read address is `cfg_tbl_base` with its low 4 bits cleared, plus the source number times 128 when `cfg_big_entry` is high, or times 16 otherwise.
- R5: In `mem_rsp_data`, memory byte k sits at bits [8k+7:8k]. Read as big-endian, bytes 0–1 form the 16-bit server field with byte 0 most significant, and byte 2 is the priority. Byte 4 bit 0 is P and byte 4 bits 2:1 are the generation. Byte 5 bit 0 is Q. Delivery carries the server field shifted right by 2.
- R6: With P=0, Q=0 and priority 0xFF, the block writes byte 0x01 at descriptor offset 5 and does not deliver.
- R7: With P=0, Q=0 and any other priority, the block writes byte (0x01 | generation<<1) at descriptor offset 4. After that write's response it pulses `dlv_valid` with the server, the priority, and the source number plus `cfg_irq_base`.
- R8: With P=1 and Q=0, the block writes byte 0x01 at offset 5 and does not deliver.
- R9: With Q=1, the trigger is dropped after the read, with no write and no delivery.
- R10: With `trig_force` high at acceptance, the descriptor's P and Q are treated as 0 whatever they hold. Priority 0xFF still selects the Q write.
- R11: An error response to the read or to the write ends the operation. It raises `err` for exactly one cycle, skips any write and delivery still to come, and returns to idle.
- R12: `dlv_valid` is high for exactly one cycle per delivery.
- R13: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address, direction and data stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger offered |
| trig_ready | output | 1 | Trigger can be taken (idle) |
| trig_src | input | 12 | Source number of the trigger |
| trig_force | input | 1 | Ignore stored P/Q flags |
| cfg_tbl_en | input | 1 | Descriptor table enabled |
| cfg_tbl_base | input | 32 | Table base address (low 4 bits ignored) |
| cfg_tbl_len | input | 13 | Number of valid sources |
| cfg_big_entry | input | 1 | Stride 128 bytes instead of 16 |
| cfg_irq_base | input | 16 | Offset added to the source number on delivery |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = byte write, 0 = 8-byte read |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | 64 | Read data, byte k at bits [8k+7:8k] |
| mem_rsp_err | input | 1 | Response reports failure |
| dlv_valid | output | 1 | Delivery pulse |
| dlv_server | output | 14 | Destination server |
| dlv_prio | output | 8 | Delivery priority |
| dlv_irq | output | 16 | Interrupt number (source + base) |
| busy | output | 1 | Operation in progress |
| err | output | 1 | One-cycle error pulse |

## Verification
The hardest states to reach from the ports are the ones that stack a stalled memory port on top of a late outcome: an error on the write that follows a successful read, or a forced replay of a descriptor whose flags would normally drop it. The bench answers every request from a responder with random ready stalls and random response latency. It builds each descriptor from chosen P, Q, priority and generation values over random filler bytes, so that directed cases hit these combinations exactly. Seeded random trials then mix flag states, force, stride, bounds and injected errors.

// File: rtl/msi_pq_pkg.sv
package msi_pq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT
  } pq_state_e;

  typedef enum logic [1:0] {
    ACT_DROP,
    ACT_SET_Q,
    ACT_SET_P
  } pq_action_e;

  localparam logic [7:0] PRIO_MASKED = 8'hFF;
  localparam int         LINK_W      = 2;
  localparam logic [2:0] OFS_P_BYTE  = 3'd4;
  localparam logic [2:0] OFS_Q_BYTE  = 3'd5;
  localparam logic [7:0] Q_SET_BYTE  = 8'h01;

endpackage

// File: rtl/msi_entry_addr.sv
module msi_entry_addr #(
  parameter int SRC_W   = 12,
  parameter int ADDR_W  = 32,
  parameter int ALIGN_W = 4,
  parameter int SMALL_SH = 4,
  parameter int BIG_SH   = 7
) (
  input  logic [SRC_W-1:0]  src,
  input  logic              tbl_en,
  input  logic [SRC_W:0]    tbl_len,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              big_entry,
  output logic              lookup_ok,
  output logic [ADDR_W-1:0] entry_addr
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((64'd1 << ALIGN_W) - 64'd1);

  logic              in_range;
  logic [ADDR_W-1:0] base_m;
  logic [ADDR_W-1:0] stride_off;

  assign in_range   = {1'b0, src} < tbl_len;
  assign lookup_ok  = tbl_en && in_range;
  assign base_m     = tbl_base & ~ALIGN_MASK;
  assign stride_off = big_entry ? (ADDR_W'(src) << BIG_SH) : (ADDR_W'(src) << SMALL_SH);
  assign entry_addr = base_m + stride_off;

endmodule

// File: rtl/msi_entry_decode.sv
module msi_entry_decode
  import msi_pq_pkg::*;
#(
  parameter int SERVER_W = 16,
  parameter int PRIO_W   = 8
) (
  input  logic [63:0]                raw,
  input  logic                       force_pq,
  output logic [SERVER_W-LINK_W-1:0] server,
  output logic [PRIO_W-1:0]          prio,
  output pq_action_e                 action,
  output logic [2:0]                 wr_off,
  output logic [7:0]                 wr_byte
);
  logic [63:0]         be;
  logic [SERVER_W-1:0] srv_field;
  logic [1:0]          gen;
  logic                flag_p, flag_q;
  logic [1:0]          pq;
  logic                unused_bits;

  for (genvar k = 0; k < 8; k++) begin : g_swap
    assign be[63-8*k -: 8] = raw[8*k +: 8];
  end

  assign srv_field = be[63 -: SERVER_W];
  assign prio      = be[63-SERVER_W -: PRIO_W];
  assign flag_p    = be[24];
  assign gen       = be[26:25];
  assign flag_q    = be[16];
  assign server    = srv_field[SERVER_W-1:LINK_W];
  assign unused_bits = ^{srv_field[LINK_W-1:0], be[63-SERVER_W-PRIO_W:27], be[23:17], be[15:0]};

  assign pq = force_pq ? 2'b00 : {flag_p, flag_q};

  always_comb begin
    action = ACT_DROP;
    unique case (pq)
      2'b00:   action = (prio == PRIO_MASKED) ? ACT_SET_Q : ACT_SET_P;
      2'b10:   action = ACT_SET_Q;
      default: action = ACT_DROP;
    endcase
  end

  assign wr_off  = (action == ACT_SET_P) ? OFS_P_BYTE : OFS_Q_BYTE;
  assign wr_byte = (action == ACT_SET_P) ? {5'b0, gen, 1'b1} : Q_SET_BYTE;

endmodule

// File: rtl/msi_pq_gate.sv
module msi_pq_gate
  import msi_pq_pkg::*;
#(
  parameter int SRC_W    = 12,
  parameter int ADDR_W   = 32,
  parameter int IRQ_W    = 16,
  parameter int SERVER_W = 16,
  parameter int PRIO_W   = 8,
  parameter int ALIGN_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trig_valid,
  output logic                       trig_ready,
  input  logic [SRC_W-1:0]           trig_src,
  input  logic                       trig_force,
  input  logic                       cfg_tbl_en,
  input  logic [ADDR_W-1:0]          cfg_tbl_base,
  input  logic [SRC_W:0]             cfg_tbl_len,
  input  logic                       cfg_big_entry,
  input  logic [IRQ_W-1:0]           cfg_irq_base,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic                       mem_req_write,
  output logic [ADDR_W-1:0]          mem_req_addr,
  output logic [7:0]                 mem_req_wdata,
  input  logic                       mem_rsp_valid,
  input  logic [63:0]                mem_rsp_data,
  input  logic                       mem_rsp_err,
  output logic                       dlv_valid,
  output logic [SERVER_W-LINK_W-1:0] dlv_server,
  output logic [PRIO_W-1:0]          dlv_prio,
  output logic [IRQ_W-1:0]           dlv_irq,
  output logic                       busy,
  output logic                       err
);
  localparam int DSRV_W = SERVER_W - LINK_W;

  pq_state_e         state;
  logic              lk_ok;
  logic [ADDR_W-1:0] lk_addr;
  logic [ADDR_W-1:0] addr_q;
  logic [IRQ_W-1:0]  irq_q;
  logic              force_q;
  pq_action_e        act_q;
  logic [2:0]        wr_off_q;
  logic [7:0]        wr_byte_q;
  logic [DSRV_W-1:0] srv_q;
  logic [PRIO_W-1:0] prio_q;

  logic [DSRV_W-1:0] dec_srv;
  logic [PRIO_W-1:0] dec_prio;
  pq_action_e        dec_act;
  logic [2:0]        dec_off;
  logic [7:0]        dec_byte;

  msi_entry_addr #(
    .SRC_W(SRC_W), .ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)
  ) u_addr (
    .src(trig_src), .tbl_en(cfg_tbl_en), .tbl_len(cfg_tbl_len),
    .tbl_base(cfg_tbl_base), .big_entry(cfg_big_entry),
    .lookup_ok(lk_ok), .entry_addr(lk_addr)
  );

  msi_entry_decode #(
    .SERVER_W(SERVER_W), .PRIO_W(PRIO_W)
  ) u_dec (
    .raw(mem_rsp_data), .force_pq(force_q),
    .server(dec_srv), .prio(dec_prio), .action(dec_act),
    .wr_off(dec_off), .wr_byte(dec_byte)
  );

  assign trig_ready    = (state == ST_IDLE);
  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign mem_req_write = (state == ST_WR_REQ);
  assign mem_req_addr  = mem_req_write ? (addr_q + ADDR_W'(wr_off_q)) : addr_q;
  assign mem_req_wdata = wr_byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      addr_q     <= '0;
      irq_q      <= '0;
      force_q    <= 1'b0;
      act_q      <= ACT_DROP;
      wr_off_q   <= '0;
      wr_byte_q  <= '0;
      srv_q      <= '0;
      prio_q     <= '0;
      dlv_valid  <= 1'b0;
      dlv_server <= '0;
      dlv_prio   <= '0;
      dlv_irq    <= '0;
      err        <= 1'b0;
    end else begin
      dlv_valid <= 1'b0;
      err       <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (trig_valid && lk_ok) begin
            addr_q  <= lk_addr;
            irq_q   <= IRQ_W'(trig_src) + cfg_irq_base;
            force_q <= trig_force;
            state   <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: if (mem_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              err   <= 1'b1;
              state <= ST_IDLE;
            end else if (dec_act == ACT_DROP) begin
              state <= ST_IDLE;
            end else begin
              act_q     <= dec_act;
              wr_off_q  <= dec_off;
              wr_byte_q <= dec_byte;
              srv_q     <= dec_srv;
              prio_q    <= dec_prio;
              state     <= ST_WR_REQ;
            end
          end
        end
        ST_WR_REQ: if (mem_req_ready) state <= ST_WR_WAIT;
        ST_WR_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              err <= 1'b1;
            end else if (act_q == ACT_SET_P) begin
              dlv_valid  <= 1'b1;
              dlv_server <= srv_q;
              dlv_prio   <= prio_q;
              dlv_irq    <= irq_q;
            end
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Assertions
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && trig_ready && cfg_tbl_en && ({1'b0, trig_src} < cfg_tbl_len)
    |=> busy && mem_req_valid && !mem_req_write);

  p_disabled_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && trig_ready && !cfg_tbl_en |=> !busy && !mem_req_valid);

  p_oob_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && trig_ready && ({1'b0, trig_src} >= cfg_tbl_len) |=> !busy && !mem_req_valid);

  p_rd_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_write |-> mem_req_addr[ALIGN_W-1:0] == '0);

  p_wr_setbit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[0]);

  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err && !dlv_valid);

  p_dlv_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |=> !dlv_valid);

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready
    |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata));

endmodule

// File: tb/msi_pq_gate_bench.sv
module msi_pq_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_valid = 1'b0;
  logic        trig_ready;
  logic [11:0] trig_src = '0;
  logic        trig_force = 1'b0;
  logic        cfg_tbl_en = 1'b0;
  logic [31:0] cfg_tbl_base = '0;
  logic [12:0] cfg_tbl_len = '0;
  logic        cfg_big_entry = 1'b0;
  logic [15:0] cfg_irq_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        dlv_valid;
  logic [13:0] dlv_server;
  logic [7:0]  dlv_prio;
  logic [15:0] dlv_irq;
  logic        busy;
  logic        err;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc_cnt  = 0;

  always #10 clk = ~clk;

  msi_pq_gate u_msi_pq_gate (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_src(trig_src), .trig_force(trig_force),
    .cfg_tbl_en(cfg_tbl_en), .cfg_tbl_base(cfg_tbl_base), .cfg_tbl_len(cfg_tbl_len),
    .cfg_big_entry(cfg_big_entry), .cfg_irq_base(cfg_irq_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .dlv_valid(dlv_valid), .dlv_server(dlv_server), .dlv_prio(dlv_prio), .dlv_irq(dlv_irq),
    .busy(busy), .err(err)
  );

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc_cnt);
      $display("  Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_raw(input logic [63:0] fill, input logic [15:0] srv,
                                         input logic [7:0] pr, input logic p, input logic q,
                                         input logic [1:0] gen);
    logic [63:0] r;
    r = fill;
    r[7:0]   = srv[15:8];
    r[15:8]  = srv[7:0];
    r[23:16] = pr;
    r[32]    = p;
    r[34:33] = gen;
    r[40]    = q;
    return r;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [11:0] src,
                                           input logic big);
    return (base & 32'hFFFF_FFF0) + (big ? 32'(src) * 32'd128 : 32'(src) * 32'd16);
  endfunction

  task automatic run_trial(input logic en, input logic [12:0] len, input logic [31:0] base,
                           input logic big, input logic [15:0] ibase, input logic [11:0] src,
                           input logic frc, input logic [63:0] raw, input logic rd_e,
                           input logic wr_e);
    int rd_n = 0, wr_n = 0, dlv_n = 0, err_n = 0, lat = 0;
    logic [31:0] rd_a = '0, wr_a = '0;
    logic [7:0]  wr_d = '0;
    logic [13:0] o_srv = '0;
    logic [7:0]  o_pr = '0;
    logic [15:0] o_irq = '0;
    bit pend = 0, pend_wr = 0, done = 0, ready_bad = 0, busy0 = 0;
    logic ok, p, q, in_rng;
    logic [1:0] gen, pq;
    logic [7:0] pr;
    logic [15:0] srv;
    int act; // 0 drop, 1 set Q, 2 set P
    string rq;

    in_rng = ({1'b0, src} < len);
    ok  = en && in_rng;
    p   = raw[32]; q = raw[40]; gen = raw[34:33]; pr = raw[23:16];
    srv = {raw[7:0], raw[15:8]};
    pq  = frc ? 2'b00 : {p, q};
    if (pq == 2'b00) act = (pr == 8'hFF) ? 1 : 2;
    else if (pq == 2'b10) act = 1;
    else act = 0;
    if (!en) rq = "R2";
    else if (!in_rng) rq = "R3";
    else if (rd_e || (wr_e && act != 0)) rq = "R11";
    else if (frc) rq = "R10";
    else if (pq[0]) rq = "R9";
    else if (pq == 2'b10) rq = "R8";
    else if (act == 1) rq = "R6";
    else rq = "R7";

    @(negedge clk);
    cfg_tbl_en = en; cfg_tbl_len = len; cfg_tbl_base = base; cfg_big_entry = big;
    cfg_irq_base = ibase; trig_src = src; trig_force = frc; trig_valid = 1'b1;
    for (int cyc = 0; cyc < 300; cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin
        trig_valid = 1'b0;
        busy0 = busy;
      end
      mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
      if (dlv_valid) begin
        dlv_n++; o_srv = dlv_server; o_pr = dlv_prio; o_irq = dlv_irq;
      end
      if (err) err_n++;
      if (busy == trig_ready) ready_bad = 1;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pend_wr ? {$urandom, $urandom} : raw;
          mem_rsp_err   = pend_wr ? wr_e : rd_e;
          pend = 0;
        end else lat--;
      end
      mem_req_ready = ($urandom_range(0, 3) != 0);
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin wr_n++; wr_a = mem_req_addr; wr_d = mem_req_wdata; end
        else begin rd_n++; rd_a = mem_req_addr; end
        pend = 1; pend_wr = mem_req_write; lat = $urandom_range(0, 2);
      end
      if (!busy && !pend && !mem_rsp_valid) begin done = 1; break; end
    end
    mem_req_ready = 1'b0;

    check(done, rq, "operation finished", 64'(done), 64'd1);
    check(!ready_bad, "R1", "trig_ready is inverse of busy", 64'(ready_bad), 64'd0);
    check(busy0 == ok, ok ? "R1" : rq, "busy after accept", 64'(busy0), 64'(ok));
    check(rd_n == (ok ? 1 : 0), rq, "read count", 64'(rd_n), 64'(ok ? 1 : 0));
    if (ok) check(rd_a == exp_addr(base, src, big), "R4", "read address", 64'(rd_a),
                  64'(exp_addr(base, src, big)));
    if (ok && !rd_e && act != 0) begin
      check(wr_n == 1, rq, "write count", 64'(wr_n), 64'd1);
      if (act == 2) begin
        check(wr_a == exp_addr(base, src, big) + 32'd4, rq, "P write address", 64'(wr_a),
              64'(exp_addr(base, src, big) + 32'd4));
        check(wr_d == {5'b0, gen, 1'b1}, rq, "P write byte", 64'(wr_d), 64'({5'b0, gen, 1'b1}));
      end else begin
        check(wr_a == exp_addr(base, src, big) + 32'd5, rq, "Q write address", 64'(wr_a),
              64'(exp_addr(base, src, big) + 32'd5));
        check(wr_d == 8'h01, rq, "Q write byte", 64'(wr_d), 64'h01);
      end
    end else begin
      check(wr_n == 0, rq, "no write", 64'(wr_n), 64'd0);
    end
    if (ok && !rd_e && act == 2 && !wr_e) begin
      check(dlv_n == 1, "R12", "one delivery pulse", 64'(dlv_n), 64'd1);
      check(o_srv == srv[15:2], "R5", "delivered server", 64'(o_srv), 64'(srv[15:2]));
      check(o_pr == pr, "R5", "delivered priority", 64'(o_pr), 64'(pr));
      check(o_irq == 16'(src) + ibase, "R7", "delivered irq", 64'(o_irq), 64'(16'(src) + ibase));
    end else begin
      check(dlv_n == 0, rq, "no delivery", 64'(dlv_n), 64'd0);
    end
    check(err_n == ((ok && (rd_e || (wr_e && act != 0))) ? 1 : 0), "R11", "error pulses",
          64'(err_n), 64'((ok && (rd_e || (wr_e && act != 0))) ? 1 : 0));
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && trig_ready && !mem_req_valid && !dlv_valid && !err, "R1", "reset state",
          {59'b0, busy, trig_ready, mem_req_valid, dlv_valid, err}, 64'b01000);

    // directed corners
    run_trial(1'b0, 13'd64, 32'h1000, 1'b0, 16'h100, 12'd3, 1'b0, mk_raw(64'h0, 16'h0040, 8'h05, 0, 0, 2'd1), 0, 0);
    run_trial(1'b1, 13'd64, 32'h1000, 1'b0, 16'h100, 12'd64, 1'b0, mk_raw(64'h0, 16'h0040, 8'h05, 0, 0, 2'd1), 0, 0);
    run_trial(1'b1, 13'd64, 32'h2007, 1'b1, 16'h20, 12'd63, 1'b0, mk_raw(64'hDEAD_BEEF_0123_4567, 16'hABCD, 8'h07, 0, 0, 2'd2), 0, 0);
    run_trial(1'b1, 13'd100, 32'h3000, 1'b0, 16'h0, 12'd9, 1'b0, mk_raw(64'hFFFF_FFFF_FFFF_FFFF, 16'h1234, 8'hFF, 0, 0, 2'd0), 0, 0);
    run_trial(1'b1, 13'd100, 32'h3000, 1'b0, 16'h400, 12'd10, 1'b0, mk_raw(64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 8'hFE, 0, 0, 2'd3), 0, 0);
    run_trial(1'b1, 13'd100, 32'h3000, 1'b0, 16'h0, 12'd11, 1'b0, mk_raw(64'h0, 16'h0010, 8'h02, 1, 0, 2'd1), 0, 0);
    run_trial(1'b1, 13'd100, 32'h3000, 1'b0, 16'h0, 12'd12, 1'b0, mk_raw(64'h0, 16'h0010, 8'h02, 0, 1, 2'd1), 0, 0);
    run_trial(1'b1, 13'd100, 32'h3000, 1'b0, 16'h0, 12'd13, 1'b0, mk_raw(64'h0, 16'h0010, 8'h02, 1, 1, 2'd1), 0, 0);
    run_trial(1'b1, 13'd100, 32'h3000, 1'b1, 16'h8, 12'd14, 1'b1, mk_raw(64'h0, 16'h0F0C, 8'h03, 1, 1, 2'd2), 0, 0);
    run_trial(1'b1, 13'd100, 32'h3000, 1'b0, 16'h8, 12'd15, 1'b1, mk_raw(64'h0, 16'h0F0C, 8'hFF, 1, 0, 2'd2), 0, 0);
    run_trial(1'b1, 13'd100, 32'h3000, 1'b0, 16'h0, 12'd16, 1'b0, mk_raw(64'h0, 16'h0010, 8'h02, 0, 0, 2'd1), 1, 0);
    run_trial(1'b1, 13'd100, 32'h3000, 1'b0, 16'h0, 12'd17, 1'b0, mk_raw(64'h0, 16'h0010, 8'h02, 0, 0, 2'd1), 0, 1);

    // seeded random mix
    for (int i = 0; i < 80; i++) begin
      logic [12:0] len;
      logic [11:0] src;
      len = 13'($urandom_range(1, 4096));
      src = ($urandom_range(0, 7) == 0) ? 12'($urandom_range(0, 4095)) : 12'($urandom % len);
      run_trial($urandom_range(0, 9) != 0, len, $urandom, 1'($urandom), 16'($urandom), src,
                $urandom_range(0, 4) == 0,
                mk_raw({$urandom, $urandom}, 16'($urandom),
                       ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom),
                       1'($urandom), ($urandom_range(0, 2) == 0), 2'($urandom)),
                $urandom_range(0, 11) == 0, $urandom_range(0, 11) == 0);
    end

    $display("  Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

endmodule